// File: doc/BRIEF.md
# BCD Seven-Segment Latching Decoder

This block turns a four-bit decimal digit into seven active-high segment drives for a common-cathode display. A hold control, active high here, decides whether the display tracks the incoming digit or shows a digit captured earlier. While hold is low, the digit input passes straight through the decoder to the segments. Every rising clock edge in that state also writes the digit into a holding register. When hold is high, the decoder reads the register instead, so the display keeps showing the last digit loaded.

Two active-low overrides act only on the segment outputs. Lamp test lights every segment and wins over everything else. Blanking turns every segment off whenever lamp test is inactive. The six codes above nine are shown dark. Digits six and nine are drawn without their tails. The interface carries no flowing data, so all pins are plain levels and there is no handshake or back-pressure.

Top module: `seg7_latch_decoder`

## Requirements
- R1: While `hold_i` is low, with both overrides inactive, `seg_o` shows the decode of the live `digit_i` in the same cycle, with no clock edge needed.
- R2: While `hold_i` is high, `seg_o` shows the digit present at the last rising clock edge on which `hold_i` was low, and changes on `digit_i` have no effect.
- R3: While `lamp_test_n_i` is low, `seg_o` equals 7'h7F, whatever the other inputs are.
- R4: While `lamp_test_n_i` is high and `blank_n_i` is low, `seg_o` equals 7'h00.
- R5: Lamp test and blanking never alter the held digit. After both overrides are released, with hold still high, the earlier digit is shown again.
- R6: The codes 10 to 15 give `seg_o` = 7'h00 when no override is active.
- R7: Segment a is bit 0 and segment g is bit 6 of `seg_o`. The digits 0 to 9 map to 3F, 06, 5B, 4F, 66, 6D, 7C, 07, 7F, 67 (hex).
- R8: A low `rst_n` sampled at a rising edge clears the held digit to 0. With hold high and no override active, `seg_o` then reads 7'h3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the holding register loads on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears the held digit |
| digit_i | input | 4 | Binary-coded decimal digit to display |
| hold_i | input | 1 | 0: transparent, and the register loads each edge; 1: show the held digit |
| lamp_test_n_i | input | 1 | Active low; lights all segments |
| blank_n_i | input | 1 | Active low; turns all segments off when lamp test is inactive |
| seg_o | output | 7 | Active-high segment drives, bit 0 = a through bit 6 = g |

## Verification
The block's only state is the held digit. A wrong stored value is invisible while hold is low, because the bypass shows live data. It appears on `seg_o` in the first cycle hold is high, as the pattern of another digit or as a dark display for a stray code above nine. The bench therefore changes the live digit right after raising hold, and again after each override pulse, so that a register that reloads or gets corrupted shows up within one cycle. A register that fails to reset shows up on the first held read after reset.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned SEG_N   = 7;
  localparam int unsigned DEC_MAX = 9;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_N-1:0]   seg_t;

  localparam seg_t SEG_ALL_ON  = {SEG_N{1'b1}};
  localparam seg_t SEG_ALL_OFF = '0;

  // bit 0 = a ... bit 6 = g; six and nine are drawn without tails
  function automatic seg_t glyph(input digit_t d);
    seg_t s;
    case (d)
      digit_t'(0): s = 7'b0111111;
      digit_t'(1): s = 7'b0000110;
      digit_t'(2): s = 7'b1011011;
      digit_t'(3): s = 7'b1001111;
      digit_t'(4): s = 7'b1100110;
      digit_t'(5): s = 7'b1101101;
      digit_t'(6): s = 7'b1111100;
      digit_t'(7): s = 7'b0000111;
      digit_t'(8): s = 7'b1111111;
      digit_t'(9): s = 7'b1100111;
      default:     s = SEG_ALL_OFF;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/seg7_digit_hold.sv
module seg7_digit_hold
  import seg7_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hold_i,
  input  digit_t digit_i,
  output digit_t digit_o
);
  digit_t held_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       held_q <= '0;
    else if (!hold_i) held_q <= digit_i;
  end

  assign digit_o = hold_i ? held_q : digit_i;

  p_held_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(held_q));
  p_load_when_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_i |=> held_q == $past(digit_i));
endmodule

// File: rtl/seg7_decode.sv
module seg7_decode
  import seg7_pkg::*;
(
  input  digit_t digit_i,
  output seg_t   seg_o
);
  logic in_range;
  assign in_range = (digit_i <= digit_t'(DEC_MAX));
  assign seg_o    = in_range ? glyph(digit_i) : SEG_ALL_OFF;
endmodule

// File: rtl/seg7_override.sv
module seg7_override
  import seg7_pkg::*;
(
  input  logic lamp_test_n_i,
  input  logic blank_n_i,
  input  seg_t seg_i,
  output seg_t seg_o
);
  always_comb begin
    if (!lamp_test_n_i)  seg_o = SEG_ALL_ON;
    else if (!blank_n_i) seg_o = SEG_ALL_OFF;
    else                 seg_o = seg_i;
  end
endmodule

// File: rtl/seg7_latch_decoder.sv
module seg7_latch_decoder
  import seg7_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] digit_i,
  input  logic       hold_i,
  input  logic       lamp_test_n_i,
  input  logic       blank_n_i,
  output logic [6:0] seg_o
);
  digit_t shown_digit;
  seg_t   raw_seg;

  seg7_digit_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (hold_i),
    .digit_i (digit_i),
    .digit_o (shown_digit)
  );

  seg7_decode u_dec (
    .digit_i (shown_digit),
    .seg_o   (raw_seg)
  );

  seg7_override u_ovr (
    .lamp_test_n_i (lamp_test_n_i),
    .blank_n_i     (blank_n_i),
    .seg_i         (raw_seg),
    .seg_o         (seg_o)
  );

  p_lamp_all_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lamp_test_n_i |-> seg_o == 7'h7F);
  p_blank_all_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_test_n_i && !blank_n_i) |-> seg_o == 7'h00);
  p_nondecimal_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_test_n_i && blank_n_i && !hold_i && digit_i > 4'd9) |-> seg_o == 7'h00);
  p_held_output_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && lamp_test_n_i && blank_n_i && $past(hold_i)
     && $past(lamp_test_n_i) && $past(blank_n_i) && $past(rst_n)) |-> $stable(seg_o));
endmodule

// File: tb/seg7_latch_decoder_tb.sv
module seg7_latch_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] digit_i;
  logic       hold_i;
  logic       lamp_test_n_i;
  logic       blank_n_i;
  logic [6:0] seg_o;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  seg7_latch_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .digit_i(digit_i), .hold_i(hold_i),
    .lamp_test_n_i(lamp_test_n_i), .blank_n_i(blank_n_i), .seg_o(seg_o)
  );

  // expected pattern built segment by segment from the lit-digit sets
  function automatic logic [6:0] expect_seg(input int d);
    logic [6:0] s;
    s = '0;
    if (d > 9) return s;
    s[0] = !(d == 1 || d == 4 || d == 6);
    s[1] = !(d == 5 || d == 6);
    s[2] = (d != 2);
    s[3] = (d == 0 || d == 2 || d == 3 || d == 5 || d == 6 || d == 8);
    s[4] = (d == 0 || d == 2 || d == 6 || d == 8);
    s[5] = (d == 0 || d == 4 || d == 5 || d == 6 || d == 8 || d == 9);
    s[6] = !(d == 0 || d == 1 || d == 7);
    return s;
  endfunction

  task automatic check(input string req, input logic [6:0] exp);
    checks++;
    if (seg_o !== exp) begin
      errors++;
      $display("FAIL %s seg_o=%h expected=%h", req, seg_o, exp);
    end
  endtask

  task automatic settle_neg();
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; digit_i = 4'd5; hold_i = 1'b1;
    lamp_test_n_i = 1'b1; blank_n_i = 1'b1;
    settle_neg(); settle_neg();
    rst_n = 1'b1; #1;
    check("R8 reset held digit zero", 7'h3F);

    // R1, R6, R7: transparent sweep of all codes
    hold_i = 1'b0;
    for (int d = 0; d < 16; d++) begin
      settle_neg();
      digit_i = 4'(d); #1;
      check(d > 9 ? "R6 non-decimal dark" : "R1 R7 live decode", expect_seg(d));
    end

    // R2: capture each code, then scramble the input while held
    for (int d = 0; d < 16; d++) begin
      settle_neg();
      hold_i = 1'b0; digit_i = 4'(d);
      settle_neg();
      hold_i = 1'b1; digit_i = 4'((d + 3) % 16); #1;
      check("R2 held after capture", expect_seg(d));
      for (int k = 1; k < 4; k++) begin
        settle_neg();
        digit_i = 4'((d + 5 * k) % 16); #1;
        check("R2 held under input churn", expect_seg(d));
      end
    end

    // R3 / R4 priority over every combination
    for (int d = 0; d < 16; d++) begin
      for (int h = 0; h < 2; h++) begin
        settle_neg();
        digit_i = 4'(d); hold_i = h[0];
        lamp_test_n_i = 1'b0; blank_n_i = 1'b0; #1;
        check("R3 lamp over blank", 7'h7F);
        lamp_test_n_i = 1'b0; blank_n_i = 1'b1; #1;
        check("R3 lamp test", 7'h7F);
        lamp_test_n_i = 1'b1; blank_n_i = 1'b0; #1;
        check("R4 blank", 7'h00);
        blank_n_i = 1'b1;
      end
    end

    // R5: overrides across clock edges leave the held digit intact
    settle_neg();
    hold_i = 1'b0; digit_i = 4'd6;
    settle_neg();
    hold_i = 1'b1; digit_i = 4'd1;
    lamp_test_n_i = 1'b0;
    settle_neg(); settle_neg();
    lamp_test_n_i = 1'b1; #1;
    check("R5 after lamp test", expect_seg(6));
    blank_n_i = 1'b0; digit_i = 4'd9;
    settle_neg(); settle_neg();
    blank_n_i = 1'b1; #1;
    check("R5 after blank", expect_seg(6));

    // R8: reset while holding a digit
    settle_neg();
    hold_i = 1'b0; digit_i = 4'd7;
    settle_neg();
    hold_i = 1'b1; #1;
    check("R2 holding seven", expect_seg(7));
    rst_n = 1'b0;
    settle_neg();
    rst_n = 1'b1; #1;
    check("R8 reset clears held", 7'h3F);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule